// File: doc/BRIEF.md
# I2C Master Byte Controller

This block is a single-master I2C engine that a host controls through a small 8-bit register port. The host sets a 16-bit clock divider and turns the core on. It then moves data one byte at a time. It loads a transmit byte, which is the slave address plus the R/W bit when a start is involved, and writes a command word.

A command word can ask for a start, a byte write, a byte read with ACK or NACK, and a stop, in any sensible combination. The core expands the command into bit-level SCL/SDA activity. Each SCL period is split into five equal phases. Both lines are open-drain: an output-enable pulls the line low, and releasing it lets the line float high.

Progress is reported through a status register with an interrupt flag, a transfer-in-progress bit, a received-ACK bit, an arbitration-lost bit and a bus-busy bit. An optional interrupt line mirrors the flag when interrupts are enabled. Bus-busy comes from START/STOP conditions seen on the synchronised bus inputs, so traffic from any master sets it.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the divider reads 0xFFFF, control reads 0x00, status reads 0x00, irq is low and both output-enables are low.
- R2: The divider is written and read as two bytes: the low byte at offset 0 and the high byte at offset 1. Writes to these offsets change nothing while control bit 7 (core enable) is set.
- R3: During data bits, SCL rises once every 5 × (divider + 1) core clocks.
- R4: Offset 2 is control, with bit 7 the core enable and bit 6 the interrupt enable. Offset 3 takes the transmit byte on a write and returns the last received byte on a read. Offset 4 takes a command on a write and returns status on a read, laid out as {rx_nack, busy, arb_lost, 0, 0, 0, tip, flag}.
- R5: The command bits are 0x80 start, 0x40 stop, 0x20 read, 0x10 write, 0x08 NACK on read, and 0x01 acknowledge the flag. Combinations such as 0x91, 0x51 and 0x69 run as one command. A command is taken only while the core is enabled and no other command is pending. The flag-acknowledge bit always takes effect.
- R6: A write sends the transmit byte MSB first, then samples the slave acknowledge bit into status bit 7 (1 = NACK).
- R7: A read shifts in 8 bits MSB first and latches them into the receive register. During the acknowledge bit the master pulls SDA low, or leaves it released when 0x08 is set.
- R8: Status bit 1 (tip) is high from the acceptance of a read or write command until that command, including any stop it requests, has finished. Status bit 0 (flag) is set when any command completes and is cleared by the acknowledge bit.
- R9: irq is high exactly when the flag is set and control bit 6 is set.
- R10: A stop requested together with a read or write follows that byte's acknowledge bit, and afterwards both lines are released.
- R11: If SDA reads low while the core is sending a 1 data bit, the command is abandoned, both lines are released, and status bits 5 and 0 are set. Bit 5 clears when the next command is accepted.
- R12: Status bit 6 is set by a START condition (SDA falls while SCL is high) and cleared by a STOP condition (SDA rises while SCL is high), whoever drives the bus.
- R13: Clearing control bit 7 releases both lines at once and drops any pending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | SCL line as seen on the bus |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_in | input | 1 | SDA line as seen on the bus |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
The main byte path is tried with random bursts of one to four random bytes. Each burst is written to a modelled slave and then read back, under two random divider settings. All-ones and all-zeros bytes are forced in, so that released-high and driven-low data bits are both seen on SDA.

Comparing the slave's stored bytes and the read-back bytes against the sent data separates bit-order faults from acknowledge faults. The master ACK/NACK pattern recorded by the slave separates the two read commands. Directed cases cover the following:
- a wrong address, which must give a NACK;
- a foreign start and stop that must toggle busy;
- disabling the core mid-start;
- a second driver holding SDA low, which must give arbitration loss.

// File: rtl/i2c_byte_master.sv
`timescale 1ns/1ps
module i2c_byte_master (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_in,
  output logic       scl_oe,
  input  logic       sda_in,
  output logic       sda_oe
);
  typedef enum logic [1:0] {S_IDLE, S_START, S_BIT, S_STOP} state_t;

  state_t      state;
  logic [15:0] pre, pcnt;
  logic        en, ien;
  logic [7:0]  txr, rxr, sh;
  logic        c_sta, c_sto, c_rd, c_wr, c_ack;
  logic        iflag, al, rx_nack, busy;
  logic [2:0]  phase;
  logic [3:0]  bitn;
  logic        scl_q, sda_q;
  logic [1:0]  scl_sy, sda_sy;
  logic        sda_p;

  logic tip, pending, tick, last_ph, sample, arb_lost, bit_val, wr_cmd, scl_s, sda_s;
  assign scl_s    = scl_sy[1];
  assign sda_s    = sda_sy[1];
  assign tip      = c_rd | c_wr;
  assign pending  = c_sta | c_sto | tip;
  assign wr_cmd   = reg_wr && reg_addr == 3'd4;
  assign tick     = state != S_IDLE && pcnt == 16'd0;
  assign last_ph  = tick && phase == 3'd4;
  assign sample   = tick && phase == 3'd2 && state == S_BIT;
  assign arb_lost = sample && bitn < 4'd8 && c_wr && sh[7] && !sda_s;
  assign bit_val  = (bitn == 4'd8) ? (c_wr | c_ack) : (c_rd | sh[7]);
  assign irq      = iflag & ien;
  assign scl_oe   = ~scl_q;
  assign sda_oe   = ~sda_q;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = pre[7:0];
      3'd1:    reg_rdata = pre[15:8];
      3'd2:    reg_rdata = {en, ien, 6'd0};
      3'd3:    reg_rdata = rxr;
      3'd4:    reg_rdata = {rx_nack, busy, al, 3'd0, tip, iflag};
      default: reg_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= 16'hFFFF;
      en  <= 1'b0;
      ien <= 1'b0;
      txr <= 8'd0;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd0: if (!en) pre[7:0]  <= reg_wdata;
        3'd1: if (!en) pre[15:8] <= reg_wdata;
        3'd2: {en, ien} <= reg_wdata[7:6];
        3'd3: txr <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      sda_p  <= 1'b1;
      busy   <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      sda_p  <= sda_s;
      if (scl_s && sda_p && !sda_s)      busy <= 1'b1;
      else if (scl_s && !sda_p && sda_s) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      pcnt  <= 16'd0;
      phase <= 3'd0;
      bitn  <= 4'd0;
      sh    <= 8'd0;
      rxr   <= 8'd0;
      {c_sta, c_sto, c_rd, c_wr, c_ack} <= 5'd0;
      iflag   <= 1'b0;
      al      <= 1'b0;
      rx_nack <= 1'b0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
    end else begin
      if (wr_cmd && reg_wdata[0]) iflag <= 1'b0;
      if (!en) begin
        state <= S_IDLE;
        {c_sta, c_sto, c_rd, c_wr, c_ack} <= 5'd0;
        scl_q <= 1'b1;
        sda_q <= 1'b1;
      end else if (state == S_IDLE) begin
        if (wr_cmd && !pending)
          {c_sta, c_sto, c_rd, c_wr, c_ack} <= reg_wdata[7:3];
        if (pending) begin
          al    <= 1'b0;
          phase <= 3'd0;
          pcnt  <= pre;
          sh    <= txr;
          bitn  <= 4'd0;
          state <= c_sta ? S_START : (tip ? S_BIT : S_STOP);
        end
      end else begin
        pcnt <= tick ? pre : pcnt - 16'd1;
        if (tick) phase <= (phase == 3'd4) ? 3'd0 : 3'(phase + 3'd1);
        case (state)
          S_START: case (phase)
            3'd0: sda_q <= 1'b1;
            3'd1: scl_q <= 1'b1;
            3'd2: sda_q <= 1'b0;
            3'd4: scl_q <= 1'b0;
            default: ;
          endcase
          S_STOP: case (phase)
            3'd0: sda_q <= 1'b0;
            3'd1: scl_q <= 1'b1;
            3'd3: sda_q <= 1'b1;
            default: ;
          endcase
          default: case (phase)
            3'd0: sda_q <= bit_val;
            3'd4: scl_q <= 1'b0;
            default: scl_q <= 1'b1;
          endcase
        endcase
        if (sample) begin
          if (bitn < 4'd8) sh <= {sh[6:0], sda_s};
          else begin
            rx_nack <= sda_s;
            if (c_rd) rxr <= sh;
          end
        end
        if (last_ph) begin
          if (state == S_START && tip) state <= S_BIT;
          else if (state == S_BIT && bitn < 4'd8) bitn <= 4'(bitn + 4'd1);
          else if (state != S_STOP && c_sto) state <= S_STOP;
          else begin
            state <= S_IDLE;
            {c_sta, c_sto, c_rd, c_wr, c_ack} <= 5'd0;
            iflag <= 1'b1;
          end
        end
        if (arb_lost) begin
          state <= S_IDLE;
          {c_sta, c_sto, c_rd, c_wr, c_ack} <= 5'd0;
          scl_q <= 1'b1;
          sda_q <= 1'b1;
          al    <= 1'b1;
          iflag <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_byte_master_chk.sv
`timescale 1ns/1ps
module i2c_byte_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic [15:0] pre,
  input logic        tip,
  input logic        iflag,
  input logic        al,
  input logic        scl_oe,
  input logic        sda_oe
);
  assert_pre_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> $stable(pre));

  assert_done_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tip) && en) |-> iflag);

  assert_arb_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(al) |-> (iflag && !scl_oe && !sda_oe));

  assert_disable_release_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!tip && !scl_oe && !sda_oe));
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pre(pre), .tip(tip),
  .iflag(iflag), .al(al), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_byte_master_test.sv
`timescale 1ns/1ps
module i2c_byte_master_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq, scl_oe, sda_oe;
  logic       slv_drv = 1'b0, rogue = 1'b0;
  wire        scl_bus = !scl_oe;
  wire        sda_bus = !(sda_oe || slv_drv || rogue);

  i2c_byte_master uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_in(scl_bus), .scl_oe(scl_oe), .sda_in(sda_bus), .sda_oe(sda_oe)
  );

  always #4 clk = ~clk;

  int nchk = 0, nbad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // SCL period monitor
  int cyc = 0, rise_last = 0, rise_prev = 0;
  logic oe_prev = 1'b0;
  always @(posedge clk) begin
    cyc++;
    if (oe_prev && !scl_oe) begin rise_prev = rise_last; rise_last = cyc; end
    oe_prev = scl_oe;
  end

  // Slave model at address 0x50
  bit   s_on = 0, s_addr = 0, s_rw = 0, s_match = 0, s_mack = 0;
  int   s_bit = 0, wp = 0, rp = 0, nrd = 0;
  logic [7:0] s_sh = 8'd0;
  logic [7:0] mem [8];
  bit   mack [8];

  always @(negedge sda_bus) if (scl_bus) begin
    s_on = 1; s_addr = 1; s_bit = -1; wp = 0; rp = 0; nrd = 0; slv_drv = 0;
  end
  always @(posedge sda_bus) if (scl_bus) begin s_on = 0; slv_drv = 0; end
  always @(posedge scl_bus) if (s_on) begin
    if (s_bit >= 0 && s_bit < 8 && (s_addr || !s_rw)) s_sh = {s_sh[6:0], sda_bus};
    else if (s_bit == 8 && !s_addr && s_rw) begin
      s_mack = sda_bus; mack[nrd % 8] = sda_bus; nrd++;
    end
  end
  always @(negedge scl_bus) if (s_on) begin
    #2;
    s_bit++;
    if (s_bit == 8) begin
      if (s_addr) begin s_match = (s_sh[7:1] == 7'h50); s_rw = s_sh[0]; slv_drv = s_match; end
      else if (!s_rw) begin mem[wp % 8] = s_sh; wp++; slv_drv = 1; end
      else slv_drv = 0;
    end else if (s_bit == 9) begin
      s_bit = 0;
      if (s_addr) begin
        s_addr = 0;
        if (!s_match) begin s_on = 0; slv_drv = 0; end
        else if (s_rw) begin s_sh = mem[rp % 8]; rp++; slv_drv = !s_sh[7]; end
        else slv_drv = 0;
      end else if (s_rw && !s_mack) begin
        s_sh = mem[rp % 8]; rp++; slv_drv = !s_sh[7];
      end else slv_drv = 0;
    end else if (s_bit > 0 && !s_addr && s_rw) begin
      s_sh = s_sh << 1; slv_drv = !s_sh[7];
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_if(input string tag);
    logic [7:0] s = 8'd0;
    int n = 0;
    while (!s[0] && n < 20000) begin rd(3'd4, s); n++; end
    chk({tag, " flag"}, int'(s[0]), 1);
  endtask

  function automatic int period(input int p);
    return 5 * (p + 1);
  endfunction

  task automatic set_pre(input int p);
    wr(3'd2, 8'h00); wr(3'd0, p[7:0]); wr(3'd1, p[15:8]); wr(3'd2, 8'hC0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, st;
    logic [7:0] data [4];
    int pre_v, nb;
    void'($urandom(32'd1234));
    repeat (5) @(posedge clk);
    rst_n = 1'b1;

    rd(3'd0, v); chk("R1 pre lo", v, 8'hFF);
    rd(3'd1, v); chk("R1 pre hi", v, 8'hFF);
    rd(3'd2, v); chk("R1 ctrl", v, 8'h00);
    rd(3'd4, v); chk("R1 status", v, 8'h00);
    chk("R1 irq/oe", {irq, scl_oe, sda_oe}, 0);

    pre_v = 2 + int'($urandom % 4);
    wr(3'd0, pre_v[7:0]); wr(3'd1, 8'h00);
    rd(3'd0, v); chk("R2 pre lo", v, pre_v);
    wr(3'd2, 8'hC0);
    rd(3'd2, v); chk("R4 ctrl", v, 8'hC0);
    wr(3'd0, 8'h77); wr(3'd1, 8'h12);
    rd(3'd0, v); chk("R2 locked lo", v, pre_v);
    rd(3'd1, v); chk("R2 locked hi", v, 0);

    // foreign start/stop
    @(negedge clk); rogue = 1'b1; repeat (6) @(negedge clk);
    rd(3'd4, v); chk("R12 foreign start busy", v[6], 1);
    rogue = 1'b0; repeat (6) @(negedge clk);
    rd(3'd4, v); chk("R12 foreign stop busy", v[6], 0);

    for (int t = 0; t < 6; t++) begin
      if (t == 3) begin pre_v = 2 + int'($urandom % 4); set_pre(pre_v); end
      nb = 1 + int'($urandom % 4);
      for (int i = 0; i < 4; i++) data[i] = 8'($urandom);
      if (t == 0) data[0] = 8'hFF;
      if (t == 1) data[0] = 8'h00;
      wr(3'd3, 8'hA0); wr(3'd4, 8'h91);
      rd(3'd4, st); chk("R8 tip during", st[1], 1);
      wait_if("R5 start+write");
      rd(3'd4, st);
      chk("R6 addr ack", st[7], 0);
      chk("R8 tip after", st[1], 0);
      chk("R12 busy held", st[6], 1);
      chk("R9 irq", irq, 1);
      for (int i = 0; i < nb; i++) begin
        wr(3'd3, data[i]); wr(3'd4, (i == nb - 1) ? 8'h51 : 8'h11);
        wait_if("R6 write");
        rd(3'd4, st); chk("R6 data ack", st[7], 0);
        if (i == 0) chk("R3 scl period", rise_last - rise_prev, period(pre_v));
      end
      rd(3'd4, st); chk("R10 busy after stop", st[6], 0);
      chk("R10 lines released", {scl_oe, sda_oe}, 0);
      chk("R6 byte count", wp, nb);
      for (int i = 0; i < nb; i++) chk("R6 slave data", mem[i], data[i]);

      wr(3'd3, 8'hA1); wr(3'd4, 8'h91);
      wait_if("R5 start read addr");
      for (int i = 0; i < nb; i++) begin
        wr(3'd4, (i == nb - 1) ? 8'h69 : 8'h21);
        wait_if("R7 read");
        rd(3'd3, v); chk("R7 read data", v, data[i]);
        chk("R7 master ack level", int'(mack[i]), (i == nb - 1) ? 1 : 0);
      end
      rd(3'd4, st); chk("R10 read stop busy", st[6], 0);
    end

    // wrong address
    wr(3'd3, 8'h42); wr(3'd4, 8'h91);
    wait_if("R6 nack addr");
    rd(3'd4, st); chk("R6 nack bit", st[7], 1);
    wr(3'd4, 8'h41);
    wait_if("R10 stop only");
    rd(3'd4, st); chk("R12 busy cleared", st[6], 0);

    // irq masking
    wr(3'd2, 8'h80);
    chk("R9 irq masked", irq, 0);
    rd(3'd4, st); chk("R8 flag kept", st[0], 1);
    wr(3'd2, 8'hC0);
    chk("R9 irq unmasked", irq, 1);
    wr(3'd4, 8'h01);
    rd(3'd4, st); chk("R8 iack clears", st[0], 0);
    chk("R9 irq after iack", irq, 0);

    // disable mid-command
    wr(3'd3, 8'hA0); wr(3'd4, 8'h90);
    repeat (3) @(negedge clk);
    wr(3'd2, 8'h00);
    rd(3'd4, st);
    chk("R13 tip dropped", st[1], 0);
    chk("R13 lines released", {scl_oe, sda_oe}, 0);
    wr(3'd4, 8'h10);
    repeat (4) @(negedge clk);
    rd(3'd4, st); chk("R5 ignored while disabled", st[1], 0);
    chk("R5 no bus activity", {scl_oe, sda_oe}, 0);
    wr(3'd2, 8'hC0);

    // arbitration loss
    wr(3'd4, 8'h81);
    wait_if("R5 start only");
    wr(3'd4, 8'h01);
    @(negedge clk); rogue = 1'b1;
    wr(3'd3, 8'h80); wr(3'd4, 8'h10);
    wait_if("R11 arb flag");
    rd(3'd4, st);
    chk("R11 arb bit", st[5], 1);
    chk("R11 tip cleared", st[1], 0);
    chk("R11 lines released", {scl_oe, sda_oe}, 0);
    @(negedge clk); rogue = 1'b0;
    repeat (6) @(negedge clk);
    rd(3'd4, st); chk("R12 busy after release", st[6], 0);
    wr(3'd4, 8'h81);
    wait_if("R11 new start");
    rd(3'd4, st); chk("R11 arb cleared", st[5], 0);
    wr(3'd4, 8'h41);
    wait_if("R10 final stop");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule